// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

The block turns single-beat read, write and refresh requests into a stream of SDRAM commands (activate, read, write, precharge, auto-refresh and no-operation). It keeps the spacing between these commands legal using cycle counts that are set at run time. A packed timing word carries three 2-bit delay fields and a page-policy bit. The precharge time arrives on its own 2-bit input. A request is held on the input until the block signals acceptance, which happens in the cycle that the final read, write or refresh command of that request appears on the command bus. Until then the block inserts any activate or precharge commands that are needed, and drives no-operation whenever no command is legal.

Two page policies are supported. In auto-precharge operation every access closes its row. In open-bank operation rows stay open, so a hit to an open row skips the activate, and a miss first closes the bank. Open-bank operation is honoured only when the bus-width input reports a 32-bit bus. Otherwise the block falls back to auto-precharge. Before an auto-refresh, every open bank is closed.

Top module: `sdram_cmd_timer`

## Requirements
- R1: `tcfg_i[1:0]` (codes 0,1,2,3) sets the activate-to-access gap to 1,2,3,4 cycles. A read or write issues exactly that many cycles after the activate of its row when nothing else is pending. The activate carries the row on `cmd_addr_o`, and the access carries the column, zero-extended.
- R2: `tcfg_i[3:2]` codes 0,1,2 give a write recovery of 1,2,3 cycles. No activate issues earlier than precharge time plus write recovery after a write.
- R3: Write-recovery code 3 raises `cfg_err_o` and behaves as 3 cycles. For the other codes, `cfg_err_o` is 0.
- R4: `tcfg_i[5:4]` codes 0,1,2,3 give a refresh busy time of 2,3,4,5 cycles. No activate issues earlier than precharge time plus refresh busy time after an auto-refresh.
- R5: `trp_i` codes 0..3 give a precharge time of 1..4 cycles. No activate issues earlier than that many cycles after a precharge or an auto-precharged read.
- R6: With `tcfg_i[6]`=0 (auto-precharge, the default), each read or write is preceded by an activate, issues with `cmd_ap_o`=1, and leaves its bank closed.
- R7: With `tcfg_i[6]`=1 and `bus_w32_i`=1, an access to the open row of a bank issues without an activate and with `cmd_ap_o`=0.
- R8: With `tcfg_i[6]`=1 and `bus_w32_i`=0, the block behaves as in R6.
- R9: In open-bank operation, a row miss issues a precharge to that bank, then an activate of the new row after the precharge time, then the access.
- R10: A refresh request precharges the open banks one per cycle, lowest index first. It issues the auto-refresh only when no bank is open and the precharge time has elapsed since the last precharge.
- R11: `cmd_o` is no-operation (0) in every cycle in which no command is legal or no request is valid. `req_ready_o` is 1 exactly in the cycle in which a read, write or auto-refresh issues.
- R12: In open-bank operation, a precharge to a written bank issues no earlier than the write recovery after the write.
- R13: After reset, all banks are closed and `cmd_o` is no-operation. Command codes are: NOP 0, ACT 1, RD 2, WR 3, PRE 4, REF 5. Request kinds on `req_kind_i` are: 0 read, 1 write, 2 or 3 refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request present, held until accepted |
| req_kind_i | input | 2 | 0 read, 1 write, 2/3 refresh |
| req_bank_i | input | BANK_W | target bank |
| req_row_i | input | ROW_W | target row |
| req_col_i | input | COL_W | target column |
| tcfg_i | input | 7 | [1:0] activate gap, [3:2] write recovery, [5:4] refresh busy, [6] open-bank policy |
| trp_i | input | 2 | precharge time code |
| bus_w32_i | input | 1 | 1 when the bus is 32 bits wide |
| req_ready_o | output | 1 | request accepted this cycle |
| cmd_o | output | 3 | command code |
| cmd_bank_o | output | BANK_W | command bank |
| cmd_addr_o | output | ROW_W | row for activate, column for access |
| cmd_ap_o | output | 1 | auto-precharge flag on read/write |
| cfg_err_o | output | 1 | reserved write-recovery code in use |

## Verification
The bench builds the block with its defaults: four banks, 12-bit rows and 8-bit columns. Four banks are enough to hold two banks open at once and to show the lowest-first precharge order before a refresh. The 2-bit codes are swept exhaustively against each other: activate gap with precharge time, write recovery with precharge time, and refresh busy with precharge time. Each combination has its expected spacing computed arithmetically. The open-bank sequence of hit, miss, second bank and refresh is repeated for all sixteen pairs of precharge and write-recovery codes. This brings within reach the case where write recovery, rather than request arrival, decides when the precharge issues.

// File: rtl/sdram_tmr_pkg.sv
package sdram_tmr_pkg;
  localparam int HOLD_W   = 4;
  localparam int TCFG_W   = 7;
  localparam int CODE_W   = 2;
  localparam int F_RCD    = 0;
  localparam int F_WREC   = 2;
  localparam int F_RBUSY  = 4;
  localparam int F_PAGE   = 6;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } sdram_cmd_e;

  typedef struct packed {
    logic [HOLD_W-1:0] rcd;
    logic [HOLD_W-1:0] wr;
    logic [HOLD_W-1:0] ras;
    logic [HOLD_W-1:0] rp;
    logic              page_open;
    logic              bad_wr;
  } tmr_cfg_t;
endpackage

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode
  import sdram_tmr_pkg::*;
(
  input  logic [TCFG_W-1:0] tcfg_i,
  input  logic [CODE_W-1:0] trp_i,
  input  logic              bus_w32_i,
  output tmr_cfg_t          cfg_o
);
  logic [CODE_W-1:0] wr_code;
  assign wr_code = tcfg_i[F_WREC +: CODE_W];

  assign cfg_o.rcd       = HOLD_W'(tcfg_i[F_RCD +: CODE_W]) + HOLD_W'(1);
  assign cfg_o.bad_wr    = &wr_code;
  // reserved code clamps to the longest legal recovery
  assign cfg_o.wr        = cfg_o.bad_wr ? HOLD_W'(3) : HOLD_W'(wr_code) + HOLD_W'(1);
  assign cfg_o.ras       = HOLD_W'(tcfg_i[F_RBUSY +: CODE_W]) + HOLD_W'(2);
  assign cfg_o.rp        = HOLD_W'(trp_i) + HOLD_W'(1);
  assign cfg_o.page_open = tcfg_i[F_PAGE] & bus_w32_i;
endmodule

// File: rtl/sdram_hold_cnt.sv
module sdram_hold_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         idle_o
);
  logic [W-1:0] cnt_q, cnt_dec;

  assign cnt_dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);
  assign idle_o  = (cnt_q == '0);

  // a new load never shortens a pending hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i && val_i > cnt_dec) cnt_q <= val_i;
    else                              cnt_q <= cnt_dec;
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  parameter int BW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             close_i,
  input  logic [BW-1:0]    bank_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [BW-1:0]    lk_bank_i,
  input  logic [ROW_W-1:0] lk_row_i,
  output logic [NB-1:0]    open_o,
  output logic             hit_o
);
  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      for (int b = 0; b < NB; b++) row_q[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (bank_i == BW'(b)) begin
          if (act_i) begin
            open_q[b] <= 1'b1;
            row_q[b]  <= row_i;
          end else if (close_i) begin
            open_q[b] <= 1'b0;
          end
        end
      end
    end
  end

  assign open_o = open_q;
  assign hit_o  = open_q[lk_bank_i] && (row_q[lk_bank_i] == lk_row_i);
endmodule

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer
  import sdram_tmr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [TCFG_W-1:0] tcfg_i,
  input  logic [CODE_W-1:0] trp_i,
  input  logic              bus_w32_i,
  output logic              req_ready_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_addr_o,
  output logic              cmd_ap_o,
  output logic              cfg_err_o
);
  localparam int NEV = 4;

  tmr_cfg_t          cfg;
  sdram_cmd_e        cmd;
  logic [BANK_W-1:0] cmd_bank, first_open;
  logic [ROW_W-1:0]  cmd_addr;
  logic              ready, is_ref, is_wr, cmd_ap;
  logic [NUM_BANKS-1:0] open_vec;
  logic              row_hit;
  logic              act_idle, rcd_idle, pre_idle;
  logic              act_load;
  logic [HOLD_W-1:0] act_val;

  sdram_cfg_decode u_dec (
    .tcfg_i    (tcfg_i),
    .trp_i     (trp_i),
    .bus_w32_i (bus_w32_i),
    .cfg_o     (cfg)
  );

  assign is_ref = req_kind_i[1];
  assign is_wr  = req_kind_i[0];

  always_comb begin
    first_open = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--)
      if (open_vec[i]) first_open = BANK_W'(i);
  end

  // command picker: one legal command per cycle, NOP otherwise
  always_comb begin
    cmd      = CMD_NOP;
    cmd_bank = req_bank_i;
    cmd_addr = req_row_i;
    ready    = 1'b0;
    if (req_valid_i) begin
      if (is_ref) begin
        if (|open_vec) begin
          cmd_bank = first_open;
          if (pre_idle) cmd = CMD_PRE;
        end else if (act_idle) begin
          cmd   = CMD_REF;
          ready = 1'b1;
        end
      end else if (open_vec[req_bank_i]) begin
        if (row_hit) begin
          cmd_addr = ROW_W'(req_col_i);
          if (rcd_idle) begin
            cmd   = is_wr ? CMD_WR : CMD_RD;
            ready = 1'b1;
          end
        end else if (pre_idle) begin
          cmd = CMD_PRE;
        end
      end else if (act_idle) begin
        cmd = CMD_ACT;
      end
    end
  end

  assign cmd_ap = (cmd == CMD_RD || cmd == CMD_WR) && !cfg.page_open;

  always_comb begin
    act_load = 1'b0;
    act_val  = '0;
    unique case (cmd)
      CMD_PRE: begin act_load = 1'b1;   act_val = cfg.rp - HOLD_W'(1); end
      CMD_RD:  begin act_load = cmd_ap; act_val = cfg.rp - HOLD_W'(1); end
      CMD_WR:  begin act_load = 1'b1;   act_val = cfg.rp + cfg.wr - HOLD_W'(1); end
      CMD_REF: begin act_load = 1'b1;   act_val = cfg.rp + cfg.ras - HOLD_W'(1); end
      default: ;
    endcase
  end

  sdram_hold_cnt #(.W(HOLD_W)) u_act_hold (
    .clk_i, .rst_ni,
    .load_i (act_load),
    .val_i  (act_val),
    .idle_o (act_idle)
  );

  sdram_hold_cnt #(.W(HOLD_W)) u_rcd_hold (
    .clk_i, .rst_ni,
    .load_i (cmd == CMD_ACT),
    .val_i  (cfg.rcd - HOLD_W'(1)),
    .idle_o (rcd_idle)
  );

  sdram_hold_cnt #(.W(HOLD_W)) u_pre_hold (
    .clk_i, .rst_ni,
    .load_i (cmd == CMD_WR),
    .val_i  (cfg.wr - HOLD_W'(1)),
    .idle_o (pre_idle)
  );

  sdram_bank_track #(.NB(NUM_BANKS), .ROW_W(ROW_W), .BW(BANK_W)) u_banks (
    .clk_i, .rst_ni,
    .act_i     (cmd == CMD_ACT),
    .close_i   (cmd == CMD_PRE || cmd_ap),
    .bank_i    (cmd_bank),
    .row_i     (req_row_i),
    .lk_bank_i (req_bank_i),
    .lk_row_i  (req_row_i),
    .open_o    (open_vec),
    .hit_o     (row_hit)
  );

  assign req_ready_o = ready;
  assign cmd_o       = cmd;
  assign cmd_bank_o  = cmd_bank;
  assign cmd_addr_o  = cmd_addr;
  assign cmd_ap_o    = cmd_ap;
  assign cfg_err_o   = cfg.bad_wr;

  // cycles since the last command of each class, saturating
  logic [NEV-1:0]    ev;
  logic [HOLD_W-1:0] since_q [NEV];
  assign ev = {cmd == CMD_REF, cmd == CMD_WR, (cmd == CMD_PRE) || cmd_ap, cmd == CMD_ACT};

  for (genvar e = 0; e < NEV; e++) begin : g_since
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               since_q[e] <= '1;
      else if (ev[e])            since_q[e] <= HOLD_W'(1);
      else if (since_q[e] != '1) since_q[e] <= since_q[e] + HOLD_W'(1);
    end
  end

  assert_rcd_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD || cmd == CMD_WR) |-> since_q[0] >= cfg.rcd);
  assert_wr_to_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> since_q[2] >= cfg.rp + cfg.wr);
  assert_ref_to_act_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> since_q[3] >= cfg.rp + cfg.ras);
  assert_pre_to_act_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> since_q[1] >= cfg.rp);
  assert_access_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD || cmd == CMD_WR) |-> open_vec[cmd_bank]);
  assert_ref_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_REF) |-> (open_vec == '0) && since_q[1] >= cfg.rp);
  assert_ready_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_REF));
  assert_wr_to_pre_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE) |-> since_q[2] >= cfg.wr);
endmodule

// File: tb/sdram_cmd_timer_test.sv
`timescale 1ns/1ps
module sdram_cmd_timer_test;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_REF = 2'd2;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0;
  logic [1:0]  req_kind_i = 0, req_bank_i = 0, trp_i = 0;
  logic [11:0] req_row_i = 0, cmd_addr_o;
  logic [7:0]  req_col_i = 0;
  logic [6:0]  tcfg_i = 0;
  logic        bus_w32_i = 1;
  logic        req_ready_o, cmd_ap_o, cfg_err_o;
  logic [2:0]  cmd_o;
  logic [1:0]  cmd_bank_o;

  sdram_cmd_timer uut (.*);

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int lg_n;
  int lg_cyc [64];
  logic [2:0]  lg_cmd [64];
  logic [1:0]  lg_bank [64];
  logic [11:0] lg_addr [64];
  logic        lg_ap [64];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_log();
    lg_n = 0;
    for (int i = 0; i < 64; i++) begin
      lg_cyc[i] = 0; lg_cmd[i] = 0; lg_bank[i] = 0; lg_addr[i] = 0; lg_ap[i] = 0;
    end
  endtask

  task automatic set_cfg(input int rcd, input int wr, input int ras, input int pg,
                         input int rp, input int w32);
    tcfg_i    = {1'(pg), 2'(ras), 2'(wr), 2'(rcd)};
    trp_i     = 2'(rp);
    bus_w32_i = 1'(w32);
  endtask

  task automatic idle(input int n);
    int bad = 0;
    @(negedge clk_i);
    req_valid_i = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      if (cmd_o != C_NOP || req_ready_o) bad++;
      @(negedge clk_i);
    end
    chk(bad == 0, "R11 idle not NOP", bad, 0);
  endtask

  task automatic run_req(input logic [1:0] k, input int b, input int row, input int col);
    int guard = 0;
    @(negedge clk_i);
    req_valid_i = 1; req_kind_i = k; req_bank_i = 2'(b);
    req_row_i = 12'(row); req_col_i = 8'(col);
    forever begin
      #1;
      if (cmd_o != C_NOP && lg_n < 64) begin
        lg_cyc[lg_n] = cyc; lg_cmd[lg_n] = cmd_o; lg_bank[lg_n] = cmd_bank_o;
        lg_addr[lg_n] = cmd_addr_o; lg_ap[lg_n] = cmd_ap_o;
        lg_n++;
      end
      if (req_ready_o) break;
      guard++;
      if (guard > 64) begin
        chk(0, "R11 request stalled", guard, 64);
        break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset();
    req_valid_i = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
  endtask

  int tw, tp, d;

  initial begin
    clear_log();
    set_cfg(0, 3, 0, 0, 0, 1);
    do_reset();
    #1;
    chk(cmd_o == C_NOP && !req_ready_o, "R13 reset state", cmd_o, 0);
    chk(cfg_err_o == 1'b1, "R3 reserved code flag", cfg_err_o, 1);

    // activate gap and precharge time, auto-precharge reads
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        set_cfg(c, 0, 0, 0, p, 1);
        idle(12);
        clear_log();
        run_req(K_RD, 0, 3, 7);
        run_req(K_RD, 0, 3, 7);
        idle(2);
        chk(lg_n == 4 && lg_cmd[0] == C_ACT && lg_cmd[1] == C_RD && lg_cmd[2] == C_ACT &&
            lg_cmd[3] == C_RD, "R6 ACT RD per access", lg_n, 4);
        chk(lg_cyc[1] - lg_cyc[0] == c + 1, "R1 ACT to RD gap", lg_cyc[1] - lg_cyc[0], c + 1);
        chk(lg_addr[0] == 12'd3 && lg_addr[1] == 12'd7, "R1 row/col on bus", lg_addr[1], 7);
        chk(lg_cyc[2] - lg_cyc[1] == p + 1, "R5 RD(ap) to ACT gap", lg_cyc[2] - lg_cyc[1], p + 1);
        chk(lg_ap[1] == 1'b1 && lg_ap[3] == 1'b1, "R6 ap flag", lg_ap[1], 1);
      end
    end

    // write recovery sweep including reserved code
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 4; p++) begin
        set_cfg(1, w, 0, 0, p, 1);
        idle(12);
        clear_log();
        run_req(K_WR, 1, 5, 2);
        run_req(K_RD, 1, 5, 2);
        idle(2);
        tw = (w == 3) ? 3 : w + 1;
        d  = lg_cyc[2] - lg_cyc[1];
        chk(lg_cmd[1] == C_WR && lg_cmd[2] == C_ACT, "R2 WR then ACT", lg_cmd[2], C_ACT);
        chk(d == p + 1 + tw, (w == 3) ? "R3 reserved as 3" : "R2 WR to ACT gap", d, p + 1 + tw);
        chk(cfg_err_o == (w == 3), "R3 error flag", cfg_err_o, (w == 3));
      end
    end

    // refresh busy sweep
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 4; p++) begin
        set_cfg(0, 0, r, 0, p, 1);
        idle(12);
        clear_log();
        run_req(K_REF, 0, 0, 0);
        run_req(K_RD, 3, 1, 1);
        idle(2);
        d = lg_cyc[1] - lg_cyc[0];
        chk(lg_n == 3 && lg_cmd[0] == C_REF && lg_cmd[1] == C_ACT, "R4 REF then ACT", lg_n, 3);
        chk(d == p + 1 + r + 2, "R4 REF to ACT gap", d, p + r + 3);
      end
    end

    // open-bank operation: hit, miss, second bank, refresh
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 4; p++) begin
        set_cfg(1, w, 0, 1, p, 1);
        do_reset();
        clear_log();
        tw = (w == 3) ? 3 : w + 1;
        tp = p + 1;
        run_req(K_WR, 2, 1, 4);
        run_req(K_RD, 2, 1, 5);
        run_req(K_RD, 2, 9, 5);
        run_req(K_RD, 0, 4, 6);
        run_req(K_REF, 0, 0, 0);
        run_req(K_RD, 2, 9, 1);
        idle(2);
        chk(lg_n == 13, "R9 command count", lg_n, 13);
        chk(lg_cmd[1] == C_WR && lg_ap[1] == 1'b0, "R7 WR keeps row open", lg_ap[1], 0);
        chk(lg_cmd[2] == C_RD && lg_ap[2] == 1'b0 && lg_cyc[2] - lg_cyc[1] == 1,
            "R7 hit skips ACT", lg_cyc[2] - lg_cyc[1], 1);
        d = (tw > 2) ? tw : 2;
        chk(lg_cmd[3] == C_PRE && lg_bank[3] == 2'd2 && lg_cyc[3] - lg_cyc[1] == d,
            "R12 WR to PRE gap", lg_cyc[3] - lg_cyc[1], d);
        chk(lg_cmd[4] == C_ACT && lg_addr[4] == 12'd9 && lg_cyc[4] - lg_cyc[3] == tp,
            "R9 miss PRE to ACT", lg_cyc[4] - lg_cyc[3], tp);
        chk(lg_cmd[5] == C_RD && lg_cyc[5] - lg_cyc[4] == 2, "R9 access after ACT",
            lg_cyc[5] - lg_cyc[4], 2);
        chk(lg_cmd[8] == C_PRE && lg_bank[8] == 2'd0 && lg_cmd[9] == C_PRE &&
            lg_bank[9] == 2'd2 && lg_cyc[9] - lg_cyc[8] == 1, "R10 PRE order", lg_bank[9], 2);
        chk(lg_cmd[10] == C_REF && lg_cyc[10] - lg_cyc[9] == tp, "R10 PRE to REF gap",
            lg_cyc[10] - lg_cyc[9], tp);
        chk(lg_cmd[11] == C_ACT && lg_cyc[11] - lg_cyc[10] == tp + 2, "R4 REF to ACT open mode",
            lg_cyc[11] - lg_cyc[10], tp + 2);
      end
    end

    // open policy requested but bus not 32 bits
    set_cfg(0, 0, 0, 1, 0, 0);
    do_reset();
    #1;
    chk(cmd_o == C_NOP, "R13 NOP after reset", cmd_o, 0);
    clear_log();
    run_req(K_RD, 1, 5, 3);
    run_req(K_RD, 1, 5, 3);
    idle(2);
    chk(lg_n == 4 && lg_cmd[2] == C_ACT, "R8 fallback reopens row", lg_n, 4);
    chk(lg_ap[1] == 1'b1 && lg_ap[3] == 1'b1, "R8 fallback ap flag", lg_ap[1], 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule